// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in physical memory. A miss arrives as a 20-bit virtual page number together with the physical page number of the current table root. The walker then issues at most two reads on its own memory read port. The first read fetches a first-level entry, indexed by the upper ten bits of the page number. If that entry is present, its page number locates a second-level table. The lower ten bits of the page number index that table to fetch the leaf entry. Table reads use physical addresses directly, with no translation.

The walk ends with a one-cycle result strobe. The result is either a translation (physical page number plus the leaf's eleven attribute bits) or a fault. A fault carries a cause code that tells an absent first-level entry apart from a leaf whose page is not resident in primary memory. Only one walk is in flight at a time, and only one memory read is outstanding at a time.

The request input and both memory channels are valid/ready. A request is taken only when `req_ready` is high, and the requester must hold it until then. The walker holds `mem_req_addr` steady while `mem_req_ready` is low. It raises `mem_rsp_ready` only while it waits for read data, and it takes that data whatever the latency. Read data offered at any other time is not consumed. The result output has no back-pressure: the consumer must take it in the strobe cycle.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress and no result is being presented. A request is captured, together with `root_ppn`, only in a cycle where `req_valid` and `req_ready` are both high. Requests presented while busy have no effect on the walk in progress.
- R2: The cycle after a request is accepted, the walker issues a read at address {root_ppn, vpn[19:10], 2'b00}, using the root captured at acceptance.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the walker keeps `mem_req_valid` high and `mem_req_addr` unchanged in the following cycle.
- R4: A first-level entry whose bit 0 (present) is 0 ends the walk with `rsp_fault`=1, `rsp_cause`=1 (absent table), `rsp_ppn`=0 and `rsp_attr`=0. No second read is issued.
- R5: When a first-level entry has bit 0 set, the next cycle issues a second read at {entry[31:12], vpn[9:0], 2'b00}.
- R6: When a leaf entry has bit 0 set, the result strobe carries `rsp_fault`=0, `rsp_cause`=0, `rsp_vpn` = the walked page number, `rsp_ppn` = leaf[31:12] and `rsp_attr` = leaf[11:1]. Of these attribute bits, bit 0 is read, bit 1 write, bit 2 execute and bit 3 user access.
- R7: A leaf entry whose bit 0 is 0 ends the walk with `rsp_fault`=1, `rsp_cause`=2 (page not resident), `rsp_ppn`=0 and `rsp_attr`=0.
- R8: `rsp_valid` is a single-cycle strobe, given once per accepted request, in the cycle after the deciding read data is taken. `req_ready` is high in the cycle that follows the strobe.
- R9: Only one read is outstanding. `mem_rsp_ready` is high only while a read is awaited, and never together with `mem_req_valid`. The walker waits any number of cycles for data, and data offered while `mem_rsp_ready` is low is ignored.
- R10: While reset (`rst_n` low) is applied, `req_ready` is 1, and `mem_req_valid`, `mem_rsp_ready` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | 20 | Virtual page number to resolve |
| root_ppn | input | 20 | Page number of the first-level table |
| mem_req_valid | output | 1 | Table read address valid |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaits read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result strobe |
| rsp_vpn | output | 20 | Page number the result belongs to |
| rsp_ppn | output | 20 | Translated physical page number, 0 on fault |
| rsp_attr | output | 11 | Leaf attribute bits, 0 on fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 absent table, 2 page not resident |

## Verification
The bound checker watches several rules on every cycle:
- the read address stays steady under back-pressure;
- a read is never issued while data is awaited;
- the strobe lasts one cycle;
- request acceptance happens only when idle.

It also computes, from each handshake, the first-level address and the second-level address. From the returned entry it derives the fault cause or the translated fields expected in the next cycle.

Other properties only the bench's scenarios can show, because they depend on the order of a whole walk and on memory behaviour. These are that a held request is the one taken once the walker is free, and that the root is sampled at acceptance rather than later. They also include arbitrary read latency with stray data offered while idle, and the mix of absent, non-resident and resident outcomes across varied page numbers and roots.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_REQ,
    WS_L1_WAIT,
    WS_L2_REQ,
    WS_L2_WAIT,
    WS_DONE,
    WS_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_ABSENT   = 2'd1,
    CAUSE_SWAPPED  = 2'd2
  } fault_cause_e;

  localparam int unsigned CAUSE_W = 2;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PTE_SHIFT = 2
) (
  input  logic             second_lvl,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] table_ppn,
  output logic [PA_W-1:0]  addr
);

  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx_lo;
  logic [IDX_W-1:0] idx_sel;
  logic [PPN_W-1:0] base_sel;

  // Upper index field selects the first-level slot, lower field the leaf slot.
  assign idx_hi   = vpn[VPN_W-1 -: IDX_W];
  assign idx_lo   = vpn[IDX_W-1:0];
  assign idx_sel  = second_lvl ? idx_lo : idx_hi;
  assign base_sel = second_lvl ? table_ppn : root_ppn;

  assign addr = (PA_W'(base_sel) << OFF_W) | (PA_W'(idx_sel) << PTE_SHIFT);

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned ATTR_W = 11
) (
  input  logic [PTE_W-1:0]  pte,
  output logic              present,
  output logic [PPN_W-1:0]  ppn,
  output logic [ATTR_W-1:0] attr
);

  assign present = pte[0];
  assign attr    = pte[ATTR_W:1];
  assign ppn     = pte[PTE_W-1 -: PPN_W];

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic pte_present,
  output logic req_ready,
  output logic mem_req_valid,
  output logic mem_rsp_ready,
  output logic second_lvl,
  output logic rsp_valid,
  output logic rsp_fault,
  output logic accept,
  output logic take_first,
  output logic take_leaf
);

  walk_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= WS_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      WS_IDLE:    if (req_valid)     nxt = WS_L1_REQ;
      WS_L1_REQ:  if (mem_req_ready) nxt = WS_L1_WAIT;
      WS_L1_WAIT: if (mem_rsp_valid) nxt = pte_present ? WS_L2_REQ : WS_FAULT;
      WS_L2_REQ:  if (mem_req_ready) nxt = WS_L2_WAIT;
      WS_L2_WAIT: if (mem_rsp_valid) nxt = pte_present ? WS_DONE : WS_FAULT;
      WS_DONE:    nxt = WS_IDLE;
      WS_FAULT:   nxt = WS_IDLE;
      default:    nxt = WS_IDLE;
    endcase
  end

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_L1_REQ) || (st == WS_L2_REQ);
  assign mem_rsp_ready = (st == WS_L1_WAIT) || (st == WS_L2_WAIT);
  assign second_lvl    = (st == WS_L2_REQ) || (st == WS_L2_WAIT);
  assign rsp_valid     = (st == WS_DONE) || (st == WS_FAULT);
  assign rsp_fault     = (st == WS_FAULT);
  assign accept        = req_ready && req_valid;
  assign take_first    = (st == WS_L1_WAIT) && mem_rsp_valid;
  assign take_leaf     = (st == WS_L2_WAIT) && mem_rsp_valid;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_BYTES = 4,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned IDX_W  = VPN_W / 2,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned PTE_W  = PTE_BYTES * 8,
  localparam int unsigned ATTR_W = OFF_W - 1,
  localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              rsp_valid,
  output logic [VPN_W-1:0]  rsp_vpn,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause
);

  logic accept, take_first, take_leaf, second_lvl;
  logic pte_present;
  logic [PPN_W-1:0]  pte_ppn;
  logic [ATTR_W-1:0] pte_attr;

  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  root_q;
  logic [PPN_W-1:0]  table_q;
  logic [PPN_W-1:0]  res_ppn_q;
  logic [ATTR_W-1:0] res_attr_q;
  fault_cause_e      cause_q;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_present   (pte_present),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .second_lvl    (second_lvl),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .accept        (accept),
    .take_first    (take_first),
    .take_leaf     (take_leaf)
  );

  ptw_addr_gen #(
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .IDX_W     (IDX_W),
    .OFF_W     (OFF_W),
    .PA_W      (PA_W),
    .PTE_SHIFT (PTE_SHIFT)
  ) u_addr (
    .second_lvl (second_lvl),
    .vpn        (vpn_q),
    .root_ppn   (root_q),
    .table_ppn  (table_q),
    .addr       (mem_req_addr)
  );

  ptw_pte_decode #(
    .PTE_W  (PTE_W),
    .PPN_W  (PPN_W),
    .ATTR_W (ATTR_W)
  ) u_dec (
    .pte     (mem_rsp_data),
    .present (pte_present),
    .ppn     (pte_ppn),
    .attr    (pte_attr)
  );

  // Request capture: root is sampled together with the page number.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      root_q <= '0;
    end else if (accept) begin
      vpn_q  <= req_vpn;
      root_q <= root_ppn;
    end
  end

  // Walk datapath: next-table pointer and result fields.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q    <= '0;
      res_ppn_q  <= '0;
      res_attr_q <= '0;
      cause_q    <= CAUSE_NONE;
    end else if (take_first) begin
      table_q <= pte_ppn;
      if (!pte_present) begin
        res_ppn_q  <= '0;
        res_attr_q <= '0;
        cause_q    <= CAUSE_ABSENT;
      end
    end else if (take_leaf) begin
      if (pte_present) begin
        res_ppn_q  <= pte_ppn;
        res_attr_q <= pte_attr;
        cause_q    <= CAUSE_NONE;
      end else begin
        res_ppn_q  <= '0;
        res_attr_q <= '0;
        cause_q    <= CAUSE_SWAPPED;
      end
    end
  end

  assign rsp_vpn   = vpn_q;
  assign rsp_ppn   = res_ppn_q;
  assign rsp_attr  = res_attr_q;
  assign rsp_cause = cause_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned ATTR_W = 11,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VPN_W-1:0]  req_vpn,
  input logic [PPN_W-1:0]  root_ppn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [PTE_W-1:0]  mem_rsp_data,
  input logic              rsp_valid,
  input logic [VPN_W-1:0]  rsp_vpn,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause
);

  localparam int unsigned IDX_W = VPN_W / 2;

  logic             lvl_q;
  logic [VPN_W-1:0] vpn_c;
  logic             rd_hs;

  assign rd_hs = mem_rsp_valid && mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      vpn_c <= '0;
    end else begin
      if (req_valid && req_ready) begin
        lvl_q <= 1'b0;
        vpn_c <= req_vpn;
      end else if (rd_hs) begin
        lvl_q <= 1'b1;
      end
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !mem_rsp_ready && !rsp_valid)); // R1

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid &&
      mem_req_addr == ((PA_W'($past(root_ppn)) << OFF_W) |
                       (PA_W'($past(req_vpn[VPN_W-1 -: IDX_W])) << PTE_SHIFT)))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

  AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !lvl_q && !mem_rsp_data[0]) |=>
      (rsp_valid && rsp_fault && rsp_cause == 2'd1 && !mem_req_valid)); // R4

  AST_LEAF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !lvl_q && mem_rsp_data[0]) |=> (mem_req_valid &&
      mem_req_addr == ((PA_W'($past(mem_rsp_data[PTE_W-1 -: PPN_W])) << OFF_W) |
                       (PA_W'(vpn_c[IDX_W-1:0]) << PTE_SHIFT)))); // R5

  AST_LEAF_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && lvl_q && mem_rsp_data[0]) |=> (rsp_valid && !rsp_fault &&
      rsp_cause == 2'd0 && rsp_vpn == vpn_c &&
      rsp_ppn == $past(mem_rsp_data[PTE_W-1 -: PPN_W]) &&
      rsp_attr == $past(mem_rsp_data[ATTR_W:1]))); // R6

  AST_SWAPPED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && lvl_q && !mem_rsp_data[0]) |=>
      (rsp_valid && rsp_fault && rsp_cause == 2'd2)); // R7

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid); // R9

endmodule

bind pt_walker pt_walker_chk #(
  .VPN_W     (VPN_W),
  .PPN_W     (PPN_W),
  .PA_W      (PA_W),
  .PTE_W     (PTE_W),
  .ATTR_W    (ATTR_W),
  .OFF_W     (OFF_W),
  .PTE_SHIFT (PTE_SHIFT)
) i_chk (.*);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  localparam int CLK_PERIOD = 10;
  localparam int CYCLE_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_vpn;
  logic [19:0] root_ppn;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic [19:0] rsp_vpn;
  logic [19:0] rsp_ppn;
  logic [10:0] rsp_attr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (.*);

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit hung = 0;

  // Physical memory and pending walks.
  logic [31:0] pmem [logic [31:0]];
  logic [19:0] vq[$];
  logic [19:0] rq[$];

  // Reference model: walk phase 0 idle,1 first read,2 first wait,3 leaf read,4 leaf wait,5 result,6 fault.
  int          p = 0;
  logic [19:0] m_vpn, m_root, m_tbl, m_ppn;
  logic [10:0] m_attr;
  int          m_cause;

  // Memory responder state.
  bit          pend = 0;
  logic [31:0] pend_addr;
  int          delay;
  int          stall_pct = 0;
  int          max_lat = 0;
  bit          stray = 0;
  bit          acc_f = 0, mreq_f = 0, mrsp_f = 0;
  logic [31:0] mreq_a;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 absent first-level entry, 1 non-resident leaf, 2 resident leaf
  task automatic add_walk(input logic [19:0] vpn, input logic [19:0] root, input int kind);
    logic [31:0] l1a, l2a, r;
    logic [19:0] tbl;
    tbl = 20'($urandom);
    r   = $urandom;
    l1a = {root, vpn[19:10], 2'b00};
    l2a = {tbl, vpn[9:0], 2'b00};
    if (kind == 0) pmem[l1a] = r & ~32'h1;
    else begin
      pmem[l1a] = {tbl, r[11:1], 1'b1};
      pmem[l2a] = (kind == 1) ? (r & ~32'h1) : (r | 32'h1);
    end
    vq.push_back(vpn);
    rq.push_back(root);
  endtask

  task automatic step();
    if (acc_f) begin void'(vq.pop_front()); void'(rq.pop_front()); end
    if (mrsp_f) pend = 0;
    if (mreq_f) begin
      pend = 1;
      pend_addr = mreq_a;
      delay = (max_lat > 0) ? int'($urandom % (max_lat + 1)) : 0;
    end

    // Compare outputs with the model.
    chk(req_ready == (p == 0), "R1 req_ready", req_ready, p == 0);
    chk(mem_req_valid == (p == 1 || p == 3), "R9 mem_req_valid", mem_req_valid, p == 1 || p == 3);
    chk(mem_rsp_ready == (p == 2 || p == 4), "R9 mem_rsp_ready", mem_rsp_ready, p == 2 || p == 4);
    chk(rsp_valid == (p >= 5), "R8 rsp_valid", rsp_valid, p >= 5);
    if (p == 1) chk(mem_req_addr == {m_root, m_vpn[19:10], 2'b00}, "R2 R3 first-level address",
                    mem_req_addr, {m_root, m_vpn[19:10], 2'b00});
    if (p == 3) chk(mem_req_addr == {m_tbl, m_vpn[9:0], 2'b00}, "R5 R3 leaf address",
                    mem_req_addr, {m_tbl, m_vpn[9:0], 2'b00});
    if (p == 5) begin
      chk(rsp_vpn == m_vpn, "R6 rsp_vpn", rsp_vpn, m_vpn);
      chk(rsp_ppn == m_ppn, "R6 rsp_ppn", rsp_ppn, m_ppn);
      chk(rsp_attr == m_attr, "R6 rsp_attr", rsp_attr, m_attr);
      chk(!rsp_fault && rsp_cause == 2'd0, "R6 no fault", {rsp_fault, rsp_cause}, 0);
    end
    if (p == 6) begin
      chk(rsp_vpn == m_vpn, (m_cause == 1) ? "R4 rsp_vpn" : "R7 rsp_vpn", rsp_vpn, m_vpn);
      chk(rsp_fault && rsp_cause == 2'(m_cause), (m_cause == 1) ? "R4 cause" : "R7 cause",
          {rsp_fault, rsp_cause}, {1'b1, 2'(m_cause)});
      chk(rsp_ppn == 0 && rsp_attr == 0, (m_cause == 1) ? "R4 zero fields" : "R7 zero fields",
          {rsp_ppn, rsp_attr}, 0);
      if (m_cause == 1) chk(!mem_req_valid, "R4 no second read", mem_req_valid, 0);
    end

    // Drive the next inputs.
    req_valid = (vq.size() > 0);
    req_vpn   = req_valid ? vq[0] : 20'($urandom);
    root_ppn  = req_valid ? rq[0] : 20'($urandom);
    mem_req_ready = ($urandom % 100) >= stall_pct;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
    if (pend) begin
      if (delay == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
      end else delay--;
    end else if (stray && ($urandom % 6 == 0)) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = $urandom | 32'h1;
    end

    acc_f  = req_valid && req_ready;
    mreq_f = mem_req_valid && mem_req_ready;
    mreq_a = mem_req_addr;
    mrsp_f = mem_rsp_valid && mem_rsp_ready;

    // Advance the model over the coming edge.
    case (p)
      0: if (req_valid) begin m_vpn = req_vpn; m_root = root_ppn; p = 1; end
      1: if (mem_req_ready) p = 2;
      2: if (mem_rsp_valid) begin
           if (mem_rsp_data[0]) begin m_tbl = mem_rsp_data[31:12]; p = 3; end
           else begin m_cause = 1; p = 6; end
         end
      3: if (mem_req_ready) p = 4;
      4: if (mem_rsp_valid) begin
           if (mem_rsp_data[0]) begin
             m_ppn = mem_rsp_data[31:12]; m_attr = mem_rsp_data[11:1]; p = 5;
           end else begin m_cause = 2; p = 6; end
         end
      default: p = 0;
    endcase

    cycles++;
    @(negedge clk);
  endtask

  task automatic run_all();
    while (!hung && (vq.size() > 0 || p != 0 || acc_f)) begin
      if (cycles > CYCLE_LIMIT) begin
        hung = 1;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, CYCLE_LIMIT);
      end else step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_vpn = 0; root_ppn = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 req_ready in reset", req_ready, 1);
    chk(!mem_req_valid && !mem_rsp_ready, "R10 memory idle in reset",
        {mem_req_valid, mem_rsp_ready}, 0);
    chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed walks, no stalls: resident, absent, non-resident, extreme page numbers, root change.
    add_walk(20'h12345, 20'h00100, 2);
    add_walk(20'h0ABCD, 20'h00100, 0);
    add_walk(20'hFEDCB, 20'h00100, 1);
    add_walk(20'hFFFFF, 20'hFFFFF, 2);
    add_walk(20'h00000, 20'h00000, 2);
    add_walk(20'h12345, 20'h00777, 2);
    run_all();

    // Random walks with back-pressure, long latency and stray read data while idle.
    stall_pct = 50;
    max_lat   = 6;
    stray     = 1;
    for (int i = 0; i < 80; i++)
      add_walk(20'($urandom), (i % 3 == 0) ? 20'h00100 : 20'($urandom), int'($urandom % 3));
    run_all();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule